// File: doc/BRIEF.md
# Page-Mode Parallel Flash Read Controller

This block sits on the host side of an asynchronous parallel NOR-type memory and turns single read requests into chip-enable, output-enable and address pin activity. A request carries a byte address and a width flag. The controller drives the pins, waits a fixed number of clock cycles, samples the data lines and returns the result with a one-cycle valid pulse. The write-enable pin is held inactive at all times.

The controller remembers the page of the previous access. A page is four 16-bit words or eight bytes. While chip enable stays asserted, a read that falls inside that page and uses the same width waits only the short page latency. Every other read waits the full access latency. Chip enable is held for a programmable number of idle cycles after a response. When that hold time runs out, chip enable is released and the remembered page is forgotten.

In byte width the memory needs one more address bit below the word address. The controller drives it on the top data line and leaves the rest of the upper data byte undriven. Only the low data byte is returned, with zeros in the upper byte.

Top module: `pgflash_rd_ctrl`

## Requirements
- R1: During and right after reset, fl_ce_n, fl_oe_n and fl_we_n are 1, req_ready is 1, rsp_valid is 0, fl_wide is 1 (word width) and dq_oe is all zeros.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the cycle after that edge through the cycle in which rsp_valid is 1, and it returns to 1 in the following cycle. rsp_valid is high for exactly one cycle per request.
- R3: From the cycle after a request is taken until the capture edge, fl_ce_n and fl_oe_n are 0 and fl_addr equals req_addr[ADDR_W-1:1] of that request. fl_we_n is always 1, and fl_oe_n is never 0 while fl_ce_n is 1.
- R4: A read that is not a page hit raises rsp_valid in the cycle that follows the FULL_LAT-th clock edge after the accepting edge.
- R5: A read is a page hit when the previous read has the same req_addr[ADDR_W-1:3] and the same req_byte value, and chip enable has stayed asserted in between. A hit raises rsp_valid after PAGE_LAT edges instead of FULL_LAT edges.
- R6: When IDLE_TMO consecutive cycles pass with req_ready at 1 and no request taken, fl_ce_n goes to 1, and the next read pays FULL_LAT. A request taken in the last of those cycles keeps chip enable asserted.
- R7: With req_byte=1 the controller sets fl_wide to 0, dq_oe to only the top bit (bit DATA_W-1), and dq_out[DATA_W-1] to req_addr[0]. rsp_data is then zeros in the upper half and dq_in[DATA_W/2-1:0] in the lower half.
- R8: With req_byte=0 the controller sets fl_wide to 1 and dq_oe to all zeros. rsp_data is the full dq_in, and req_addr[0] has no effect on the pins or on the page-hit decision.
- R9: A read whose width differs from the previous read is never a page hit and pays FULL_LAT, even when it targets the same page.
- R10: rsp_data holds the value dq_in had just before the capture edge, which is the last wait cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | ADDR_W | Byte address of the read |
| req_byte | input | 1 | 1 = byte width, 0 = word width |
| rsp_valid | output | 1 | One-cycle pulse with the read result |
| rsp_data | output | DATA_W | Read result |
| fl_ce_n | output | 1 | Memory chip enable, active low |
| fl_oe_n | output | 1 | Memory output enable, active low |
| fl_we_n | output | 1 | Memory write enable, held high |
| fl_wide | output | 1 | Width select to memory, 1 = word |
| fl_addr | output | ADDR_W-1 | Word address pins |
| dq_in | input | DATA_W | Data lines as seen by the controller |
| dq_out | output | DATA_W | Value the controller drives on the data lines |
| dq_oe | output | DATA_W | Per-line drive enable for dq_out |

## Verification
The bench sends requests with idle gaps of exactly IDLE_TMO-1 and IDLE_TMO cycles. A keeper that is off by one cycle would either drop chip enable while a hit is still allowed, or keep a page alive that should be forgotten. The bench also switches width inside a single page, to catch a page tracker that compares only the address. It changes req_addr[0] in word width, to catch a design that lets that bit split a page. Because dq_in changes on every cycle, a capture one edge early or late returns a visibly wrong word. Byte reads check the top data line, so an address bit driven onto the wrong line or left floating is detected.

// File: rtl/pgflash_pkg.sv
package pgflash_pkg;

   typedef enum logic [1:0] {
      PGF_IDLE = 2'd0,
      PGF_WAIT = 2'd1,
      PGF_RESP = 2'd2
   } pgf_state_t;

   function automatic int unsigned pgf_cnt_width(input int unsigned max_val);
      int unsigned w;
      w = 1;
      while ((1 << w) <= max_val) w++;
      return w;
   endfunction

endpackage

// File: rtl/pgflash_page_tracker.sv
module pgflash_page_tracker #(
   parameter int unsigned TAG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             drop,
   input  logic [TAG_W-1:0] probe_tag,
   input  logic             probe_byte,
   output logic             hit
);

   logic             open_q;
   logic [TAG_W-1:0] tag_q;
   logic             byte_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         tag_q  <= '0;
         byte_q <= 1'b0;
      end else if (load) begin
         open_q <= 1'b1;
         tag_q  <= probe_tag;
         byte_q <= probe_byte;
      end else if (drop) begin
         open_q <= 1'b0;
      end
   end

   assign hit = open_q && (tag_q == probe_tag) && (byte_q == probe_byte);

endmodule

// File: rtl/pgflash_wait_timer.sv
module pgflash_wait_timer #(
   parameter int unsigned FULL_LAT = 5,
   parameter int unsigned PAGE_LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic short_wait,
   output logic expire
);
   import pgflash_pkg::*;

   localparam int unsigned CNT_W = pgf_cnt_width(FULL_LAT);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;

   generate
      if (PAGE_LAT == FULL_LAT) begin : g_one_lat
         assign load_val = CNT_W'(FULL_LAT);
      end else begin : g_two_lat
         assign load_val = short_wait ? CNT_W'(PAGE_LAT) : CNT_W'(FULL_LAT);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pgflash_ce_keeper.sv
module pgflash_ce_keeper #(
   parameter int unsigned IDLE_TMO = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic open_req,
   input  logic idle_tick,
   output logic ce_on,
   output logic close_now
);
   import pgflash_pkg::*;

   localparam int unsigned IW = pgf_cnt_width(IDLE_TMO);

   logic [IW-1:0] idle_q;
   logic          on_q;

   assign close_now = idle_tick && on_q && (idle_q == IW'(IDLE_TMO - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q   <= 1'b0;
         idle_q <= '0;
      end else if (open_req) begin
         on_q   <= 1'b1;
         idle_q <= '0;
      end else if (close_now) begin
         on_q   <= 1'b0;
         idle_q <= '0;
      end else if (idle_tick && on_q) begin
         idle_q <= idle_q + 1'b1;
      end
   end

   assign ce_on = on_q;

endmodule

// File: rtl/pgflash_pin_mux.sv
module pgflash_pin_mux #(
   parameter int unsigned ADDR_W       = 24,
   parameter int unsigned DATA_W       = 16,
   parameter bit          BYTE_MODE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              load_byte,
   input  logic              capture,
   input  logic [DATA_W-1:0] dq_in,
   output logic [ADDR_W-2:0] fl_addr,
   output logic              fl_wide,
   output logic [DATA_W-1:0] dq_out,
   output logic [DATA_W-1:0] dq_oe,
   output logic [DATA_W-1:0] rsp_data
);

   localparam int unsigned HALF_W = DATA_W / 2;
   localparam int unsigned TOP    = DATA_W - 1;

   logic [ADDR_W-2:0] addr_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (load) begin
         addr_q <= load_addr[ADDR_W-1:1];
      end
   end

   assign fl_addr  = addr_q;
   assign rsp_data = data_q;

   generate
      if (BYTE_MODE_EN) begin : g_dual_width
         logic byte_q;
         logic lsb_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               byte_q <= 1'b0;
               lsb_q  <= 1'b0;
            end else if (load) begin
               byte_q <= load_byte;
               lsb_q  <= load_addr[0];
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data_q <= '0;
            end else if (capture) begin
               data_q <= byte_q ? {{(DATA_W - HALF_W){1'b0}}, dq_in[HALF_W-1:0]} : dq_in;
            end
         end

         assign fl_wide = !byte_q;
         assign dq_oe   = byte_q ? {1'b1, {(DATA_W - 1){1'b0}}} : '0;
         assign dq_out  = {lsb_q && byte_q, {(DATA_W - 1){1'b0}}};
      end else begin : g_word_only
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data_q <= '0;
            end else if (capture) begin
               data_q <= dq_in;
            end
         end

         assign fl_wide = 1'b1;
         assign dq_oe   = '0;
         assign dq_out  = '0;
      end
   endgenerate

   logic unused_top;
   assign unused_top = load_byte & dq_in[TOP];

endmodule

// File: rtl/pgflash_rd_ctrl.sv
module pgflash_rd_ctrl #(
   parameter int unsigned ADDR_W       = 24,
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned FULL_LAT     = 5,
   parameter int unsigned PAGE_LAT     = 2,
   parameter int unsigned IDLE_TMO     = 4,
   parameter bit          BYTE_MODE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_byte,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              fl_ce_n,
   output logic              fl_oe_n,
   output logic              fl_we_n,
   output logic              fl_wide,
   output logic [ADDR_W-2:0] fl_addr,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic [DATA_W-1:0] dq_oe
);
   import pgflash_pkg::*;

   localparam int unsigned TAG_W = ADDR_W - 3;

   generate
      if (FULL_LAT < 1)         begin : g_bad_full  $error("FULL_LAT must be at least 1"); end
      if (PAGE_LAT < 1)         begin : g_bad_page  $error("PAGE_LAT must be at least 1"); end
      if (PAGE_LAT > FULL_LAT)  begin : g_bad_order $error("PAGE_LAT must not exceed FULL_LAT"); end
      if (IDLE_TMO < 1)         begin : g_bad_tmo   $error("IDLE_TMO must be at least 1"); end
      if (ADDR_W < 4)           begin : g_bad_addr  $error("ADDR_W must be at least 4"); end
      if ((DATA_W % 2) != 0 || DATA_W < 4) begin : g_bad_data $error("DATA_W must be even and at least 4"); end
   endgenerate

   pgf_state_t state_q;
   logic       accept;
   logic       eff_byte;
   logic       page_hit;
   logic       expire;
   logic       ce_on;
   logic       close_now;
   logic       idle_tick;
   logic       oe_q;
   logic       rsp_q;

   assign req_ready = (state_q == PGF_IDLE);
   assign accept    = req_valid && req_ready;
   assign eff_byte  = BYTE_MODE_EN && req_byte;
   assign idle_tick = (state_q == PGF_IDLE) && !req_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PGF_IDLE;
         oe_q    <= 1'b0;
         rsp_q   <= 1'b0;
      end else begin
         rsp_q <= 1'b0;
         unique case (state_q)
            PGF_IDLE: if (accept) begin
               state_q <= PGF_WAIT;
               oe_q    <= 1'b1;
            end
            PGF_WAIT: if (expire) begin
               state_q <= PGF_RESP;
               oe_q    <= 1'b0;
               rsp_q   <= 1'b1;
            end
            default: state_q <= PGF_IDLE;
         endcase
      end
   end

   pgflash_page_tracker #(.TAG_W(TAG_W)) u_page (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .drop       (close_now),
      .probe_tag  (req_addr[ADDR_W-1:3]),
      .probe_byte (eff_byte),
      .hit        (page_hit)
   );

   pgflash_wait_timer #(.FULL_LAT(FULL_LAT), .PAGE_LAT(PAGE_LAT)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .short_wait (page_hit && ce_on),
      .expire     (expire)
   );

   pgflash_ce_keeper #(.IDLE_TMO(IDLE_TMO)) u_ce (
      .clk       (clk),
      .rst_n     (rst_n),
      .open_req  (accept),
      .idle_tick (idle_tick),
      .ce_on     (ce_on),
      .close_now (close_now)
   );

   pgflash_pin_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_MODE_EN(BYTE_MODE_EN)) u_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_addr (req_addr),
      .load_byte (eff_byte),
      .capture   (expire && (state_q == PGF_WAIT)),
      .dq_in     (dq_in),
      .fl_addr   (fl_addr),
      .fl_wide   (fl_wide),
      .dq_out    (dq_out),
      .dq_oe     (dq_oe),
      .rsp_data  (rsp_data)
   );

   assign fl_ce_n   = !ce_on;
   assign fl_oe_n   = !oe_q;
   assign fl_we_n   = 1'b1;
   assign rsp_valid = rsp_q;

endmodule

// File: rtl/pgflash_rd_ctrl_chk.sv
module pgflash_rd_ctrl_chk #(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              fl_ce_n,
   input logic              fl_oe_n,
   input logic              fl_we_n,
   input logic              fl_wide,
   input logic [ADDR_W-2:0] fl_addr,
   input logic [DATA_W-1:0] dq_oe
);

   assert_we_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fl_we_n == 1'b1);

   assert_oe_under_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_oe_n |-> !fl_ce_n);

   assert_accept_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!fl_oe_n && !fl_ce_n));

   assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_oe_n && $past(!fl_oe_n)) |-> $stable(fl_addr));

   assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_busy_on_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   assert_ready_after_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> req_ready);

   assert_byte_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_wide |-> (dq_oe[DATA_W-1] && $countones(dq_oe) == 1));

   assert_word_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fl_wide |-> (dq_oe == '0));

endmodule

bind pgflash_rd_ctrl pgflash_rd_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .fl_ce_n   (fl_ce_n),
   .fl_oe_n   (fl_oe_n),
   .fl_we_n   (fl_we_n),
   .fl_wide   (fl_wide),
   .fl_addr   (fl_addr),
   .dq_oe     (dq_oe)
);

// File: tb/pgflash_rd_ctrl_tb.sv
`timescale 1ns/1ps
module pgflash_rd_ctrl_tb;

   localparam int AW   = 12;
   localparam int DW   = 16;
   localparam int FL   = 5;
   localparam int PL   = 2;
   localparam int TMO  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic          req_byte = 1'b0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_data;
   logic          fl_ce_n, fl_oe_n, fl_we_n, fl_wide;
   logic [AW-2:0] fl_addr;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out, dq_oe;

   always #2.5 clk = ~clk;

   pgflash_rd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .FULL_LAT(FL), .PAGE_LAT(PL),
                     .IDLE_TMO(TMO), .BYTE_MODE_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_byte(req_byte), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
      .fl_wide(fl_wide), .fl_addr(fl_addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference: phase 0 idle, 1 waiting, 2 responding
   int            m_ph = 0, m_left = 0, m_idle = 0;
   bit            m_ce = 0, m_oe = 0, m_open = 0, m_pbyte = 0, m_used = 0;
   int            m_ptag = 0;
   bit            m_byte = 0;
   logic [AW-1:0] m_addr = '0;
   logic [DW-1:0] m_data = '0;
   string         m_lab = "R4";

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_left = 0; m_idle = 0; m_ce = 0; m_oe = 0; m_open = 0;
         m_pbyte = 0; m_used = 0; m_byte = 0; m_addr = '0;
      end else begin
         case (m_ph)
            0: begin
               if (req_valid) begin
                  int tag;
                  bit hit;
                  tag = int'(req_addr >> 3);
                  hit = m_open && m_ce && (tag == m_ptag) && (m_pbyte == req_byte);
                  if (hit)                             m_lab = "R5";
                  else if (m_open && m_pbyte != req_byte) m_lab = "R9";
                  else if (m_used && !m_ce)            m_lab = "R6";
                  else                                 m_lab = "R4";
                  m_left = hit ? PL : FL;
                  m_open = 1; m_ptag = tag; m_pbyte = req_byte; m_used = 1;
                  m_ce = 1; m_oe = 1; m_byte = req_byte; m_addr = req_addr;
                  m_ph = 1;
               end else if (m_ce) begin
                  m_idle++;
                  if (m_idle == TMO) begin m_ce = 0; m_open = 0; end
               end
            end
            1: begin
               m_left--;
               if (m_left == 0) begin
                  m_data = m_byte ? {8'h00, dq_in[7:0]} : dq_in;
                  m_oe = 0;
                  m_ph = 2;
               end
            end
            default: begin
               m_ph = 0; m_idle = 0;
            end
         endcase
      end
   end

   // compare on every cycle, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) begin
            check("R1 ce_n", fl_ce_n, 1);
            check("R1 oe_n", fl_oe_n, 1);
            check("R1 we_n", fl_we_n, 1);
            check("R1 ready", req_ready, 1);
            check("R1 rsp_valid", rsp_valid, 0);
            check("R1 wide", fl_wide, 1);
            check("R1 dq_oe", dq_oe, 0);
         end else begin
            check(m_ph == 0 ? "R6 ce_n" : "R3 ce_n", fl_ce_n, !m_ce);
            check("R3 oe_n", fl_oe_n, !m_oe);
            check("R3 we_n", fl_we_n, 1);
            check("R2 ready", req_ready, m_ph == 0);
            check({m_lab, " rsp_valid timing"}, rsp_valid, m_ph == 2);
            if (m_ph == 2)
               check(m_byte ? "R7,R10 data" : "R8,R10 data", rsp_data, m_data);
            if (m_oe)
               check("R3 addr", fl_addr, m_addr[AW-1:1]);
            if (m_used) begin
               check(m_byte ? "R7 wide" : "R8 wide", fl_wide, !m_byte);
               check(m_byte ? "R7 dq_oe" : "R8 dq_oe", dq_oe, m_byte ? 16'h8000 : 16'h0000);
               if (m_byte) check("R7 a-1 line", dq_out[DW-1], m_addr[0]);
            end
         end
      end
   end

   // data lines change every cycle so a mistimed capture is visible (R10)
   int ncyc = 0;
   always @(negedge clk) begin
      ncyc++;
      dq_in <= 16'(ncyc * 40503 + 7);
   end

   task automatic rd(input logic [AW-1:0] a, input bit b, input int gap);
      while (!req_ready) @(negedge clk);
      repeat (gap) @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      req_byte  = b;
      @(negedge clk);
      req_valid = 1'b0;
      req_addr  = ~a;
      req_byte  = !b;
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      int seed;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(12'h100, 0, 0);          // R4 first access
      rd(12'h102, 0, 0);          // R5 same page
      rd(12'h107, 0, 1);          // R5/R8: bit 0 ignored in word width
      rd(12'h106, 0, 0);          // R8 same word, other bit 0
      rd(12'h108, 0, 0);          // R4 new page
      rd(12'h109, 1, 0);          // R9 width change in same page
      rd(12'h10A, 1, 0);          // R5/R7 byte hit
      rd(12'h10F, 1, 2);          // R7 odd byte
      rd(12'h10C, 1, TMO);        // R6 chip enable dropped
      rd(12'h10D, 1, TMO - 1);    // R6 last idle cycle still a hit
      rd(12'h10C, 0, 0);          // R9 back to word width
      rd(12'h10C, 0, TMO + 3);    // R6 long gap
      seed = 12345;
      for (int i = 0; i < 60; i++) begin
         seed = seed * 1103515245 + 12345;
         rd(AW'(12'h200 + ((seed >>> 8) & 31)), (seed >>> 16) & 1, (seed >>> 20) & 7);
      end
      while (!req_ready) @(negedge clk);
      repeat (TMO + 3) @(negedge clk);
      done = 1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL R2 watchdog act=hung exp=finished");
         finish_run();
      end
   end

endmodule